// File: doc/BRIEF.md
# Zero-Crossing Timeout Monitor

This block watches for missing zero crossings on one voltage channel and three current channels. Each of the four monitored channels has its own down-counter. A counter is loaded from a shared programmable timeout value and steps down once for every pulse on a slow 16 kHz tick enable (62.5 µs per step). A zero-crossing pulse on the channel reloads its counter. If a tick arrives while an armed counter already sits at zero, no crossing came in time. The block then raises that channel's sticky timeout flag, and the counter stays at zero until it is reloaded.

Six current-channel crossing inputs exist, but only three current monitors. A group-select pin routes either the first three inputs or the last three inputs to the monitors. Changing the select restarts the three current monitors, so the newly chosen channels get a full timeout period.

A small register write port sets the timeout value and clears flags by writing ones. The port has no back-pressure and accepts a write in every cycle that `wr_en_i` is high. There is no data stream. All other pins are plain control or status pins.

Top module: `zxto_monitor`

## Requirements
- R1: After reset the timeout value reads 0xFFFF, all four flags read 0, and every counter is loaded with 0xFFFF and armed.
- R2: A counter steps down by one only in a cycle where `tick_i` is high. After a reload with value V, the channel's flag rises on the (V+1)-th tick and not on any earlier tick.
- R3: A crossing pulse reloads that channel's counter with the timeout value and re-arms it. A crossing in the same cycle as a tick wins, so no flag is raised in that cycle.
- R4: The flag bit order is fixed. Bit 0 is the voltage monitor. Bits 1, 2 and 3 are current monitors 0, 1 and 2, which carry channels A/B/C when the select is 0 and D/E/F when it is 1. A flag is set only by its own channel's expiry.
- R5: After expiring, a counter holds zero and raises no further event until a crossing, a timeout write or a group change reloads it. A crossing after expiry restarts a full timeout period.
- R6: With `grp_sel_i`=0, `zx_cur_i[2:0]` feed current monitors 0..2. With `grp_sel_i`=1, `zx_cur_i[5:3]` feed them. Crossings on the unselected three inputs have no effect.
- R7: A change of `grp_sel_i` reloads and re-arms the three current counters in the following cycle. The voltage counter is not affected.
- R8: A write to address 0 stores `wr_data_i` as the new timeout value and reloads all four counters with it.
- R9: A write to address 1 clears each flag whose bit in `wr_data_i[3:0]` is 1 and leaves the others. Flags are otherwise sticky. An expiry in the same cycle as a clear of that bit leaves the flag set.
- R10: With the timeout value 0xFFFF, a flag rises on the 65536th tick after reload, which is about 4.096 s at 16 kHz.
- R11: Writes to addresses 2 and 3 change neither the timeout value nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 16 kHz step enable, one cycle wide |
| zx_volt_i | input | 1 | Voltage channel crossing pulse |
| zx_cur_i | input | 6 | Current channel crossing pulses A..F (bit 0 = A) |
| grp_sel_i | input | 1 | Current group select: 0 = A/B/C, 1 = D/E/F |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 timeout, 1 flag clear |
| wr_data_i | input | 16 | Write data |
| tmo_value_o | output | 16 | Current timeout value |
| tmo_flag_o | output | 4 | Sticky timeout flags (bit 0 voltage, bits 3:1 current) |

## Verification
All internal state of this block shows up at the ports through the exact tick on which a flag rises. A counter that is off by one, decrements outside a tick or misses a reload therefore moves the rising edge of a flag by at least one tick, and the flag becomes visible one clock after the deciding tick. Routing or group-change faults show as a current flag that rises in spite of crossings on the selected input, or that fails to rise after crossings on an unselected input. The tests count ticks from a known reload and sample the flags exactly one tick before and at the expected expiry.

// File: rtl/zxto_pkg.sv
package zxto_pkg;
  localparam int TMO_W_DEF  = 16;
  localparam int N_CUR_DEF  = 3;
  localparam int ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] ADDR_TMO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLR = 2'd1;

  typedef enum logic {
    MON_RUN  = 1'b0,
    MON_DONE = 1'b1
  } mon_state_e;
endpackage

// File: rtl/zxto_regs.sv
module zxto_regs
  import zxto_pkg::*;
#(
  parameter int TMO_W = TMO_W_DEF,
  parameter int N_MON = N_CUR_DEF + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMO_W-1:0]  wr_data,
  output logic [TMO_W-1:0]  tmo_q,
  output logic [TMO_W-1:0]  load_val,
  output logic              load_all,
  output logic [N_MON-1:0]  clr_mask
);
  logic hit_tmo, hit_clr;

  assign hit_tmo  = wr_en && (wr_addr == ADDR_TMO);
  assign hit_clr  = wr_en && (wr_addr == ADDR_CLR);
  assign load_all = hit_tmo;
  assign load_val = hit_tmo ? wr_data : tmo_q;
  assign clr_mask = hit_clr ? wr_data[N_MON-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= '1;
    else if (hit_tmo) tmo_q <= wr_data;
  end

  AST_TMO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_TMO) |=> tmo_q == $past(wr_data)); // R8
  AST_OTHER_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_TMO) |=> $stable(tmo_q)); // R11
endmodule

// File: rtl/zxto_route.sv
module zxto_route #(
  parameter int N_CUR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grp_sel,
  input  logic [2*N_CUR-1:0] zx_cur,
  output logic [N_CUR-1:0]   zx_sel,
  output logic               grp_chg
);
  logic grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= 1'b0;
    else grp_q <= grp_sel;
  end

  assign grp_chg = grp_sel ^ grp_q;

  for (genvar i = 0; i < N_CUR; i++) begin : g_mux
    assign zx_sel[i] = grp_sel ? zx_cur[N_CUR + i] : zx_cur[i];
  end
endmodule

// File: rtl/zxto_chan.sv
module zxto_chan
  import zxto_pkg::*;
#(
  parameter int TMO_W = TMO_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [TMO_W-1:0] load_val,
  output logic             fire
);
  logic [TMO_W-1:0] cnt;
  mon_state_e       st;

  assign fire = tick && !reload && (st == MON_RUN) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1;
      st  <= MON_RUN;
    end else if (reload) begin
      cnt <= load_val;
      st  <= MON_RUN;
    end else if (tick && st == MON_RUN) begin
      if (cnt == '0) st <= MON_DONE;
      else cnt <= cnt - 1'b1;
    end
  end

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(load_val)) && (st == MON_RUN)); // R3
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && st == MON_RUN && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt)); // R2
  AST_EXPIRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MON_DONE && !reload) |=> (cnt == '0) && (st == MON_DONE) && !fire); // R5
endmodule

// File: rtl/zxto_flags.sv
module zxto_flags #(
  parameter int N_MON = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MON-1:0] fire,
  input  logic [N_MON-1:0] clr,
  output logic [N_MON-1:0] flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= (flag_q & ~clr) | fire;
  end

  AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |=> (flag_q & $past(fire)) == $past(fire)); // R9
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> (flag_q & ~$past(flag_q)) == '0); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R9
endmodule

// File: rtl/zxto_monitor.sv
module zxto_monitor
  import zxto_pkg::*;
#(
  parameter int TMO_W = TMO_W_DEF,
  parameter int N_CUR = N_CUR_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               zx_volt_i,
  input  logic [2*N_CUR-1:0] zx_cur_i,
  input  logic               grp_sel_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [TMO_W-1:0]   wr_data_i,
  output logic [TMO_W-1:0]   tmo_value_o,
  output logic [N_CUR:0]     tmo_flag_o
);
  localparam int N_MON = N_CUR + 1;

  logic [TMO_W-1:0] load_val;
  logic             load_all;
  logic [N_MON-1:0] clr_mask;
  logic [N_CUR-1:0] zx_sel;
  logic             grp_chg;
  logic [N_MON-1:0] reload;
  logic [N_MON-1:0] fire;

  zxto_regs #(.TMO_W(TMO_W), .N_MON(N_MON)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .tmo_q(tmo_value_o), .load_val(load_val),
    .load_all(load_all), .clr_mask(clr_mask)
  );

  zxto_route #(.N_CUR(N_CUR)) u_route (
    .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel_i), .zx_cur(zx_cur_i),
    .zx_sel(zx_sel), .grp_chg(grp_chg)
  );

  assign reload[0] = load_all | zx_volt_i;
  for (genvar i = 0; i < N_CUR; i++) begin : g_cur_reload
    assign reload[i+1] = load_all | grp_chg | zx_sel[i];
  end

  for (genvar m = 0; m < N_MON; m++) begin : g_mon
    zxto_chan #(.TMO_W(TMO_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .reload(reload[m]),
      .load_val(load_val), .fire(fire[m])
    );
  end

  zxto_flags #(.N_MON(N_MON)) u_flags (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clr(clr_mask), .flag_q(tmo_flag_o)
  );

  AST_VOLT_IGNORES_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_chg && !load_all && !zx_volt_i) |-> !reload[0]); // R7
endmodule

// File: tb/zxto_monitor_tb_top.sv
`timescale 1ns/1ps
module zxto_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        zx_volt_i = 1'b0;
  logic [5:0]  zx_cur_i = '0;
  logic        grp_sel_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] tmo_value_o;
  logic [3:0]  tmo_flag_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  zxto_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .zx_volt_i(zx_volt_i),
    .zx_cur_i(zx_cur_i), .grp_sel_i(grp_sel_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .tmo_value_o(tmo_value_o),
    .tmo_flag_o(tmo_flag_o)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    for (int k = 0; k < n; k++) cyc();
    tick_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic cur_pulse(input int idx);
    zx_cur_i[idx] = 1'b1;
    cyc();
    zx_cur_i = '0;
  endtask

  task automatic t_reset();
    check("R1 timeout value", tmo_value_o, 32'hFFFF);
    check("R1 flags", tmo_flag_o, 32'h0);
  endtask

  task automatic t_expiry();
    wr(2'd0, 16'd3);
    check("R8 value written", tmo_value_o, 32'd3);
    ticks(3);
    check("R2 no flag one tick early", tmo_flag_o, 32'h0);
    ticks(1);
    check("R2 R4 all flags at V+1 ticks", tmo_flag_o, 32'hF);
  endtask

  task automatic t_clear();
    wr(2'd1, 16'h5);
    check("R9 partial clear", tmo_flag_o, 32'hA);
    wr(2'd1, 16'h0);
    check("R9 zero clear no effect", tmo_flag_o, 32'hA);
    wr(2'd1, 16'hF);
    check("R9 full clear", tmo_flag_o, 32'h0);
  endtask

  task automatic t_hold();
    ticks(10);
    check("R5 expired counters stay quiet", tmo_flag_o, 32'h0);
    zx_volt_i = 1'b1; cyc(); zx_volt_i = 1'b0;
    ticks(3);
    check("R5 restart no early flag", tmo_flag_o, 32'h0);
    ticks(1);
    check("R5 restart fires voltage", tmo_flag_o, 32'h1);
    wr(2'd1, 16'hF);
  endtask

  task automatic t_cross();
    wr(2'd0, 16'd3);
    ticks(3);
    tick_i = 1'b1; zx_volt_i = 1'b1; cyc(); tick_i = 1'b0; zx_volt_i = 1'b0;
    check("R3 crossing beats tick", tmo_flag_o, 32'hE);
    ticks(3);
    check("R3 reloaded voltage not yet", tmo_flag_o, 32'hE);
    ticks(1);
    check("R3 reloaded voltage fires", tmo_flag_o, 32'hF);
    wr(2'd1, 16'hF);
  endtask

  task automatic t_grp0();
    wr(2'd0, 16'd3);
    ticks(2);
    cur_pulse(3);
    ticks(2);
    check("R6 unselected D ignored", tmo_flag_o, 32'hF);
    wr(2'd1, 16'hF);
    wr(2'd0, 16'd3);
    ticks(2);
    cur_pulse(0);
    ticks(2);
    check("R6 R4 channel A reloads bit1", tmo_flag_o, 32'hD);
    ticks(2);
    check("R6 channel A fires later", tmo_flag_o, 32'hF);
    wr(2'd1, 16'hF);
  endtask

  task automatic t_grp_change();
    wr(2'd0, 16'd3);
    ticks(2);
    grp_sel_i = 1'b1;
    cyc();
    ticks(2);
    check("R7 only voltage fires", tmo_flag_o, 32'h1);
    ticks(2);
    check("R7 current monitors full period", tmo_flag_o, 32'hF);
    wr(2'd1, 16'hF);
    wr(2'd0, 16'd3);
    ticks(2);
    cur_pulse(4);
    ticks(2);
    check("R6 R4 channel E reloads bit2", tmo_flag_o, 32'hB);
    wr(2'd1, 16'hF);
  endtask

  task automatic t_set_wins();
    wr(2'd0, 16'd0);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'hF;
    cyc();
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R9 expiry beats clear", tmo_flag_o, 32'hF);
  endtask

  task automatic t_other_addr();
    wr(2'd2, 16'h0001);
    wr(2'd3, 16'h000F);
    check("R11 value unchanged", tmo_value_o, 32'h0);
    check("R11 flags unchanged", tmo_flag_o, 32'hF);
    wr(2'd1, 16'hF);
  endtask

  task automatic t_max();
    wr(2'd0, 16'hFFFF);
    ticks(65535);
    check("R10 no flag before 65536 ticks", tmo_flag_o, 32'h0);
    ticks(1);
    check("R10 flags at 65536 ticks", tmo_flag_o, 32'hF);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_expiry();
    t_clear();
    t_hold();
    t_cross();
    t_grp0();
    t_grp_change();
    t_set_wins();
    t_other_addr();
    t_max();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule